// File: doc/BRIEF.md
# Bimodal Branch Predictor with Resolution Manager

This block guesses the direction of conditional branches for an in-order pipeline and corrects the pipeline when a guess proves wrong. It holds a direct-mapped table of 2-bit saturating counters. The fetch stage presents a program counter on the lookup port. One cycle later the block returns a registered taken/not-taken guess, together with the table index that was used. Fetch sends that index down the pipe with the instruction, along with both possible next addresses: the branch target and the sequential address.

When the branch resolves in execute, the pipeline presents the index, the guessed direction, the real direction and both carried addresses on the resolve port. The manager trains the selected counter toward the real outcome. If the guess was wrong, it raises a one-cycle flush and supplies the redirect address one cycle later. It does not need to recompute any address, because both candidates arrive with the branch.

Top module: `bimodal_bp`

## Requirements
- R1: After reset every counter holds 2'b01 (weakly not taken), so any lookup predicts not taken; `flush` is low while reset is applied and in the first cycle after it.
- R2: The table index is `lk_pc[IDX_W+1:2]`. Bits [1:0] are ignored, and addresses that differ only above bit IDX_W+1 share one entry. `pred_idx` returns the index that was used.
- R3: A lookup predicts taken exactly when the selected counter is 2'b10 or 2'b11.
- R4: A resolve with `rs_taken`=1 increments the counter at `rs_idx`, which saturates at 2'b11.
- R5: A resolve with `rs_taken`=0 decrements the counter at `rs_idx`, which saturates at 2'b00.
- R6: When `rs_valid` is high and `rs_pred_taken` differs from `rs_taken`, `flush` is high in the next cycle. `redirect_pc` then equals `rs_tgt_taken` if `rs_taken`=1, or `rs_tgt_seq` otherwise.
- R7: A resolve whose prediction matches the outcome trains the counter but leaves `flush` low in the next cycle.
- R8: When a lookup and a resolve select the same index in the same cycle, the lookup returns the prediction from the counter value before that update.
- R9: Outputs are registered. `pred_valid` is high in the cycle after a cycle with `lk_valid` high, and low otherwise. `flush` is low in any cycle that follows a cycle with `rs_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | ADDR_W | Fetch program counter |
| pred_valid | output | 1 | Registered prediction is valid |
| pred_taken | output | 1 | Predicted direction |
| pred_idx | output | IDX_W | Table index used by the lookup |
| rs_valid | input | 1 | Branch resolution present |
| rs_idx | input | IDX_W | Index carried with the branch |
| rs_pred_taken | input | 1 | Direction that was predicted |
| rs_taken | input | 1 | Actual direction |
| rs_tgt_taken | input | ADDR_W | Branch target address |
| rs_tgt_seq | input | ADDR_W | Sequential (fall-through) address |
| flush | output | 1 | One-cycle mispredict flush |
| redirect_pc | output | ADDR_W | Corrected fetch address, valid with flush |

## Verification
The bench builds the block with ENTRIES=8 and ADDR_W=32, so IDX_W is 3. With an 8-entry table, two program counters 32 bytes apart land on the same counter, which makes aliasing through the index bits directly observable. It also keeps training a single counter from 2'b00 up to 2'b11 and back down to a handful of cycles. The same parameter choice lets an untouched neighbouring entry be checked next to a trained one.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
    ctr_t nxt;
    if (up) nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
    else    nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx
);
  logic unused_pc_bits;

  assign idx = pc[IDX_W+1:2];
  assign unused_pc_bits = ^{pc[ADDR_W-1:IDX_W+2], pc[1:0]};
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_taken,
  output logic [IDX_W-1:0] rd_idx_q,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);

  ctr_t [ENTRIES-1:0] cnt;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    ctr_t c;
    always_ff @(posedge clk) begin
      if (rst)
        c <= CTR_WEAK_NT;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        c <= ctr_step(c, wr_up);
    end
    assign cnt[i] = c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_taken <= 1'b0;
      rd_idx_q <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_taken <= ctr_says_taken(cnt[rd_idx]);
        rd_idx_q <= rd_idx;
      end
    end
  end

  AST_TRAIN_UP_NEVER_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_up) |=> (cnt[$past(wr_idx)] >= $past(cnt[wr_idx]))); // R4

  AST_TRAIN_DOWN_NEVER_RAISES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_up) |=> (cnt[$past(wr_idx)] <= $past(cnt[wr_idx]))); // R5

  AST_READ_SEES_OLD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && rd_idx == wr_idx) |=> (rd_taken == $past(cnt[rd_idx][1]))); // R8

endmodule

// File: rtl/bp_resolver.sv
module bp_resolver #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rs_valid,
  input  logic [IDX_W-1:0]  rs_idx,
  input  logic              rs_pred_taken,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_tgt_taken,
  input  logic [ADDR_W-1:0] rs_tgt_seq,
  output logic              train_en,
  output logic [IDX_W-1:0]  train_idx,
  output logic              train_up,
  output logic              flush,
  output logic [ADDR_W-1:0] redirect_pc
);

  logic wrong_guess;

  assign wrong_guess = rs_valid && (rs_pred_taken != rs_taken);
  assign train_en    = rs_valid;
  assign train_idx   = rs_idx;
  assign train_up    = rs_taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush       <= 1'b0;
      redirect_pc <= '0;
    end else begin
      flush <= wrong_guess;
      if (wrong_guess)
        redirect_pc <= rs_taken ? rs_tgt_taken : rs_tgt_seq;
    end
  end

  AST_MISS_FLUSHES: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_pred_taken != rs_taken) |=> flush); // R6

  AST_MISS_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && !rs_pred_taken && rs_taken) |=> (redirect_pc == $past(rs_tgt_taken))); // R6

  AST_MISS_SEQ_TARGET: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_pred_taken && !rs_taken) |=> (redirect_pc == $past(rs_tgt_seq))); // R6

  AST_HIT_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_pred_taken == rs_taken) |=> !flush); // R7

  AST_IDLE_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
    !rs_valid |=> !flush); // R9

endmodule

// File: rtl/bimodal_bp.sv
module bimodal_bp #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [IDX_W-1:0]  pred_idx,
  input  logic              rs_valid,
  input  logic [IDX_W-1:0]  rs_idx,
  input  logic              rs_pred_taken,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_tgt_taken,
  input  logic [ADDR_W-1:0] rs_tgt_seq,
  output logic              flush,
  output logic [ADDR_W-1:0] redirect_pc
);

  logic [IDX_W-1:0] lk_idx;
  logic             train_en;
  logic [IDX_W-1:0] train_idx;
  logic             train_up;

  bp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_index (
    .pc  (lk_pc),
    .idx (lk_idx)
  );

  bp_counter_table #(.ENTRIES(ENTRIES)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (lk_valid),
    .rd_idx   (lk_idx),
    .rd_valid (pred_valid),
    .rd_taken (pred_taken),
    .rd_idx_q (pred_idx),
    .wr_en    (train_en),
    .wr_idx   (train_idx),
    .wr_up    (train_up)
  );

  bp_resolver #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_resolver (
    .clk           (clk),
    .rst           (rst),
    .rs_valid      (rs_valid),
    .rs_idx        (rs_idx),
    .rs_pred_taken (rs_pred_taken),
    .rs_taken      (rs_taken),
    .rs_tgt_taken  (rs_tgt_taken),
    .rs_tgt_seq    (rs_tgt_seq),
    .train_en      (train_en),
    .train_idx     (train_idx),
    .train_up      (train_up),
    .flush         (flush),
    .redirect_pc   (redirect_pc)
  );

  AST_LOOKUP_YIELDS_PRED: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid); // R9

  AST_NO_LOOKUP_NO_PRED: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid); // R9

  AST_INDEX_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (pred_idx == $past(lk_pc[IDX_W+1:2]))); // R2

endmodule

// File: tb/sim_bimodal_bp.sv
module sim_bimodal_bp;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NE = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          lk_valid;
  logic [AW-1:0] lk_pc;
  logic          pred_valid;
  logic          pred_taken;
  logic [IW-1:0] pred_idx;
  logic          rs_valid;
  logic [IW-1:0] rs_idx;
  logic          rs_pred_taken;
  logic          rs_taken;
  logic [AW-1:0] rs_tgt_taken;
  logic [AW-1:0] rs_tgt_seq;
  logic          flush;
  logic [AW-1:0] redirect_pc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bimodal_bp #(.ADDR_W(AW), .ENTRIES(NE)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_idx(pred_idx),
    .rs_valid(rs_valid), .rs_idx(rs_idx), .rs_pred_taken(rs_pred_taken),
    .rs_taken(rs_taken), .rs_tgt_taken(rs_tgt_taken), .rs_tgt_seq(rs_tgt_seq),
    .flush(flush), .redirect_pc(redirect_pc)
  );

  typedef struct packed {
    logic          lv;
    logic [AW-1:0] pc;
    logic          rv;
    logic [IW-1:0] ri;
    logic          rp;
    logic          rt;
    logic [AW-1:0] tt;
    logic [AW-1:0] ts;
    logic          epv;
    logic          ep;
    logic [IW-1:0] ei;
    logic          ef;
    logic [AW-1:0] er;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h04, 1'b0, 3'd0, 1'b0, 1'b0, 32'h0,   32'h0,  1'b1, 1'b0, 3'd1, 1'b0, 32'h0},
    '{1'b1, 32'h04, 1'b1, 3'd1, 1'b0, 1'b1, 32'h100, 32'h08, 1'b1, 1'b0, 3'd1, 1'b1, 32'h100},
    '{1'b1, 32'h04, 1'b1, 3'd1, 1'b1, 1'b1, 32'h100, 32'h08, 1'b1, 1'b1, 3'd1, 1'b0, 32'h0},
    '{1'b1, 32'h24, 1'b1, 3'd1, 1'b1, 1'b1, 32'h100, 32'h08, 1'b1, 1'b1, 3'd1, 1'b0, 32'h0},
    '{1'b1, 32'h04, 1'b1, 3'd1, 1'b1, 1'b0, 32'h200, 32'h28, 1'b1, 1'b1, 3'd1, 1'b1, 32'h28},
    '{1'b1, 32'h07, 1'b1, 3'd1, 1'b1, 1'b0, 32'h200, 32'h30, 1'b1, 1'b1, 3'd1, 1'b1, 32'h30},
    '{1'b1, 32'h04, 1'b0, 3'd0, 1'b0, 1'b0, 32'h0,   32'h0,  1'b1, 1'b0, 3'd1, 1'b0, 32'h0},
    '{1'b1, 32'h08, 1'b1, 3'd1, 1'b0, 1'b0, 32'h0,   32'h0,  1'b1, 1'b0, 3'd2, 1'b0, 32'h0},
    '{1'b0, 32'h04, 1'b1, 3'd1, 1'b0, 1'b0, 32'h0,   32'h0,  1'b0, 1'b0, 3'd0, 1'b0, 32'h0},
    '{1'b1, 32'h04, 1'b1, 3'd1, 1'b0, 1'b1, 32'h400, 32'h08, 1'b1, 1'b0, 3'd1, 1'b1, 32'h400},
    '{1'b1, 32'h04, 1'b0, 3'd0, 1'b0, 1'b0, 32'h0,   32'h0,  1'b1, 1'b0, 3'd1, 1'b0, 32'h0},
    '{1'b1, 32'h08, 1'b0, 3'd0, 1'b0, 1'b0, 32'h0,   32'h0,  1'b1, 1'b0, 3'd2, 1'b0, 32'h0}
  };

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    lk_valid = 0; lk_pc = '0; rs_valid = 0; rs_idx = '0;
    rs_pred_taken = 0; rs_taken = 0; rs_tgt_taken = '0; rs_tgt_seq = '0;
  endtask

  // drive at negedge, let one rising edge pass, sample 1 time unit later
  task automatic cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic resolve(input logic [IW-1:0] idx, input logic p, input logic t);
    @(negedge clk);
    drive_idle();
    rs_valid = 1; rs_idx = idx; rs_pred_taken = p; rs_taken = t;
    cycle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    drive_idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 flush in reset", {31'd0, flush}, 32'd0);
    chk("R9 pred_valid in reset", {31'd0, pred_valid}, 32'd0);
    @(negedge clk);
    rst = 0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      lk_valid = VEC[v].lv; lk_pc = VEC[v].pc;
      rs_valid = VEC[v].rv; rs_idx = VEC[v].ri; rs_pred_taken = VEC[v].rp;
      rs_taken = VEC[v].rt; rs_tgt_taken = VEC[v].tt; rs_tgt_seq = VEC[v].ts;
      cycle();
      chk($sformatf("R9 v%0d pred_valid", v), {31'd0, pred_valid}, {31'd0, VEC[v].epv});
      if (VEC[v].epv) begin
        chk($sformatf("R3/R4/R5/R8 v%0d pred_taken", v), {31'd0, pred_taken}, {31'd0, VEC[v].ep});
        chk($sformatf("R2 v%0d pred_idx", v), {29'd0, pred_idx}, {29'd0, VEC[v].ei});
      end
      chk($sformatf("R6/R7 v%0d flush", v), {31'd0, flush}, {31'd0, VEC[v].ef});
      if (VEC[v].ef)
        chk($sformatf("R6 v%0d redirect_pc", v), redirect_pc, VEC[v].er);
    end

    // R4: train idx 3 to strongly taken, check prediction
    @(negedge clk);
    drive_idle();
    resolve(3'd3, 1'b1, 1'b1);
    resolve(3'd3, 1'b1, 1'b1);
    @(negedge clk);
    drive_idle();
    lk_valid = 1; lk_pc = 32'h0C;
    cycle();
    chk("R4 idx3 trained taken", {31'd0, pred_taken}, 32'd1);

    // R1: reset restores weakly not taken
    @(negedge clk);
    drive_idle();
    rst = 1;
    cycle();
    @(negedge clk);
    rst = 0;
    lk_valid = 1; lk_pc = 32'h0C;
    cycle();
    chk("R1 idx3 after reset", {31'd0, pred_taken}, 32'd0);
    chk("R1 flush after reset", {31'd0, flush}, 32'd0);

    // R1: one taken resolve from reset state reaches the taken threshold
    resolve(3'd3, 1'b0, 1'b1);
    chk("R1 flush after weak miss", {31'd0, flush}, 32'd1);
    @(negedge clk);
    drive_idle();
    lk_valid = 1; lk_pc = 32'h1000_000C;
    cycle();
    chk("R1 weak entry crosses after one up", {31'd0, pred_taken}, 32'd1);
    chk("R2 high bits ignored", {29'd0, pred_idx}, 32'd3);

    // R9: idle resolve port, flush drops
    @(negedge clk);
    drive_idle();
    cycle();
    chk("R9 flush idle", {31'd0, flush}, 32'd0);
    chk("R9 pred_valid idle", {31'd0, pred_valid}, 32'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule